// File: doc/BRIEF.md
# Multi-Generator Quadratic-Residue Word Source

This block turns eight small quadratic-residue generators into one stream of 32-bit words. Each generator keeps a state below 2^16 and a modulus. On every step it squares its state and reduces the result modulo its own modulus. All eight generators share one sequential multiply-and-reduce unit, so only one of them steps at a time.

For each word, the block steps the generators in a fixed schedule and builds a word `t` from the low bits of their results. It first packs four bits from each of the eight generators. It then applies two shift-and-insert stages, and the shift amount of each stage comes from another generator step. The finished `t` is XORed into a running 32-bit value, and the new running value is the output word. A call asks for `n` words. When the call ends, the eight states move one slot up.

Software loads a state and a modulus into each slot, one slot per load. Each load is screened for weak seeds. The block refuses to start a call while any slot holds a rejected pair.

Top module: `bbs_word_gen`

## Requirements
- R1: Each generator step replaces the selected slot state `s` with `(s*s) mod m`, where `m` is that slot's modulus. Every step takes exactly 34 clock cycles, so within one call consecutive `word_valid_o` pulses are exactly 408 cycles apart.
- R2: Every reduction result is strictly below the modulus it was reduced by.
- R3: A word starts by stepping slots 0,1,...,7 in that order. After each step, `t` is shifted left by 4 and the low 4 bits of the result are placed in bits 3:0. Slot 0's bits therefore end up in `t[31:28]` before the extra stages.
- R4: Two extra stages follow. In the first, slot 2 is stepped and the low 2 bits of its result give a shift amount `a`. Slot 0 is then stepped, `t` is shifted left by `a`, and the result ANDed with a mask is ORed in. The mask is 0, 1, 3 or 7 for `a` = 0, 1, 2 or 3. The second stage works the same way, with slot 6 giving the amount and slot 1 giving the inserted bits. A word therefore takes 12 steps.
- R5: The running value resets to 0. Each finished `t` is XORed into it, and the new value appears on `word_o` together with a one-cycle `word_valid_o` pulse. `word_o` changes at no other time.
- R6: After the last word of a call, the state in slot i moves to slot (i+1) mod 8, including the states updated during that call. The moduli stay in their slots.
- R7: A load writes the seed and modulus into slot `load_slot_i` and marks the slot rejected if seed < 2, modulus < 2, or gcd(seed, modulus) is not 1. A later good load clears the mark. `load_err_o` is high while any slot is rejected, and all slots start out rejected after reset.
- R8: `start_i` is ignored while `load_err_o` is high, while the block is busy, while `load_i` is high, or when `n_words_i` is 0.
- R9: `load_i` is ignored while a call is running; it changes neither the slots nor `load_err_o`.
- R10: `done_o` pulses together with the last `word_valid_o` of a call, and `busy_o` is low in that same cycle.
- R11: After reset, `busy_o`, `word_valid_o` and `done_o` are 0, `word_o` is 0 and `load_err_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load request for one slot |
| load_slot_i | input | 3 | Slot index 0..7 |
| load_seed_i | input | 16 | Seed state |
| load_mod_i | input | 16 | Modulus |
| start_i | input | 1 | Start a call |
| n_words_i | input | 8 | Number of words in the call |
| busy_o | output | 1 | Seed check or call in progress |
| load_err_o | output | 1 | At least one slot holds a rejected pair |
| word_o | output | 32 | Running output value |
| word_valid_o | output | 1 | New word on `word_o` |
| done_o | output | 1 | Last word of a call |

## Verification
The slot rotation at the end of a call is the hardest thing to observe. It only becomes visible through the words of the next call, and only if the moduli in neighbouring slots differ. The bench loads eight distinct moduli, runs calls of several lengths back to back, and keeps comparing against a model that applies the rotation. A wrong rotation direction or a wrong source state therefore corrupts the following words. Rejected loads and loads attempted mid-call are mixed between these calls, so that an ignored load is checked by whether the later words still match the model.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  localparam int unsigned NGEN   = 8;
  localparam int unsigned SLOT_W = $clog2(NGEN);
  localparam int unsigned NSTEP  = 12;
  localparam int unsigned STEP_W = $clog2(NSTEP);

  typedef enum logic [1:0] {S_IDLE, S_CHK, S_ISSUE, S_WAIT} fsm_e;

  // slot stepped at each position of the per-word schedule
  function automatic logic [SLOT_W-1:0] slot_of_step(input logic [STEP_W-1:0] k);
    case (k)
      4'd8:    slot_of_step = SLOT_W'(2);
      4'd9:    slot_of_step = SLOT_W'(0);
      4'd10:   slot_of_step = SLOT_W'(6);
      4'd11:   slot_of_step = SLOT_W'(1);
      default: slot_of_step = k[SLOT_W-1:0];
    endcase
  endfunction

  function automatic logic [2:0] ins_mask(input logic [1:0] a);
    case (a)
      2'd0:    ins_mask = 3'd0;
      2'd1:    ins_mask = 3'd1;
      2'd2:    ins_mask = 3'd3;
      default: ins_mask = 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/bbs_coprime_chk.sv
module bbs_coprime_chk #(
  parameter int unsigned XW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [XW-1:0] a_i,
  input  logic [XW-1:0] b_i,
  output logic          done_o,
  output logic          coprime_o
);
  logic [XW-1:0] a_q, b_q;
  logic          run_q;

  // binary gcd; only coprimality is needed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0; b_q <= '0; run_q <= 1'b0; done_o <= 1'b0; coprime_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        a_q <= a_i; b_q <= b_i; run_q <= 1'b1;
      end else if (run_q) begin
        if (a_q == '0 || b_q == '0) begin
          run_q <= 1'b0; done_o <= 1'b1; coprime_o <= 1'b0;
        end else if (!a_q[0] && !b_q[0]) begin
          run_q <= 1'b0; done_o <= 1'b1; coprime_o <= 1'b0;
        end else if (!a_q[0]) begin
          a_q <= a_q >> 1;
        end else if (!b_q[0]) begin
          b_q <= b_q >> 1;
        end else if (a_q == b_q) begin
          run_q <= 1'b0; done_o <= 1'b1; coprime_o <= (a_q == XW'(1));
        end else if (a_q > b_q) begin
          a_q <= a_q - b_q;
        end else begin
          b_q <= b_q - a_q;
        end
      end
    end
  end
endmodule

// File: rtl/bbs_modsq.sv
module bbs_modsq #(
  parameter int unsigned XW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [XW-1:0] x_i,
  input  logic [XW-1:0] m_i,
  output logic          done_o,
  output logic [XW-1:0] r_o
);
  localparam int unsigned PW    = 2 * XW;
  localparam int unsigned CNT_W = $clog2(PW);

  logic [PW-1:0]    prod_q;
  logic [XW:0]      rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [XW:0]      rem_sh;

  assign rem_sh = {rem_q[XW-1:0], prod_q[PW-1]};
  assign r_o    = rem_q[XW-1:0];

  // restoring reduction, one product bit per cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0; rem_q <= '0; cnt_q <= '0; run_q <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        prod_q <= x_i * x_i;
        rem_q  <= '0;
        cnt_q  <= '0;
        run_q  <= 1'b1;
      end else if (run_q) begin
        prod_q <= prod_q << 1;
        rem_q  <= (rem_sh >= {1'b0, m_i}) ? rem_sh - {1'b0, m_i} : rem_sh;
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(PW - 1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bbs_word_shaper.sv
module bbs_word_shaper
  import bbs_pkg::*;
#(
  parameter int unsigned XW = 16,
  parameter int unsigned WW = 32
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [WW-1:0]     t_i,
  input  logic [1:0]        amt_i,
  input  logic [XW-1:0]     r_i,
  output logic [WW-1:0]     t_o,
  output logic [1:0]        amt_o
);
  always_comb begin
    t_o   = t_i;
    amt_o = amt_i;
    case (step_i)
      4'd8, 4'd10: amt_o = r_i[1:0];
      4'd9, 4'd11: t_o = (t_i << amt_i) | WW'(r_i[2:0] & ins_mask(amt_i));
      default:     t_o = {t_i[WW-5:0], r_i[3:0]};
    endcase
  end
endmodule

// File: rtl/bbs_word_gen.sv
module bbs_word_gen
  import bbs_pkg::*;
#(
  parameter int unsigned XW = 16,
  parameter int unsigned WW = 32,
  parameter int unsigned CW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SLOT_W-1:0] load_slot_i,
  input  logic [XW-1:0]     load_seed_i,
  input  logic [XW-1:0]     load_mod_i,
  input  logic              start_i,
  input  logic [CW-1:0]     n_words_i,
  output logic              busy_o,
  output logic              load_err_o,
  output logic [WW-1:0]     word_o,
  output logic              word_valid_o,
  output logic              done_o
);
  fsm_e              state_q;
  logic [XW-1:0]     st_q [NGEN];
  logic [XW-1:0]     md_q [NGEN];
  logic [XW-1:0]     st_upd [NGEN];
  logic [XW-1:0]     st_rot [NGEN];
  logic [NGEN-1:0]   bad_q;
  logic [SLOT_W-1:0] chk_slot_q;
  logic              chk_range_q;
  logic [STEP_W-1:0] step_q;
  logic [CW-1:0]     left_q;
  logic [WW-1:0]     t_q, x_q, t_nx;
  logic [1:0]        amt_q, amt_nx;
  logic              load_acc, start_acc, chk_done, chk_cop;
  logic              red_start, red_done, run_phase, word_end, call_end;
  logic [XW-1:0]     red_r, cur_mod, cur_state;
  logic [SLOT_W-1:0] gen_sel;

  assign load_acc   = (state_q == S_IDLE) && load_i;
  assign start_acc  = (state_q == S_IDLE) && !load_i && start_i && !load_err_o && (n_words_i != '0);
  assign busy_o     = (state_q != S_IDLE);
  assign load_err_o = |bad_q;
  assign run_phase  = (state_q == S_ISSUE) || (state_q == S_WAIT);
  assign gen_sel    = slot_of_step(step_q);
  assign cur_mod    = md_q[gen_sel];
  assign cur_state  = st_q[gen_sel];
  assign red_start  = (state_q == S_ISSUE);
  assign word_end   = (state_q == S_WAIT) && red_done && (step_q == STEP_W'(NSTEP - 1));
  assign call_end   = word_end && (left_q == CW'(1));

  bbs_coprime_chk #(.XW(XW)) u_chk (
    .clk_i, .rst_ni, .start_i(load_acc), .a_i(load_seed_i), .b_i(load_mod_i),
    .done_o(chk_done), .coprime_o(chk_cop)
  );

  bbs_modsq #(.XW(XW)) u_red (
    .clk_i, .rst_ni, .start_i(red_start), .x_i(cur_state), .m_i(cur_mod),
    .done_o(red_done), .r_o(red_r)
  );

  bbs_word_shaper #(.XW(XW), .WW(WW)) u_shp (
    .step_i(step_q), .t_i(t_q), .amt_i(amt_q), .r_i(red_r), .t_o(t_nx), .amt_o(amt_nx)
  );

  for (genvar g = 0; g < NGEN; g++) begin : g_slot
    assign st_upd[g] = (gen_sel == SLOT_W'(g)) ? red_r : st_q[g];
    assign st_rot[(g + 1) % NGEN] = st_upd[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      for (int i = 0; i < NGEN; i++) begin
        st_q[i] <= '0;
        md_q[i] <= '0;
      end
      bad_q        <= '1;
      chk_slot_q   <= '0;
      chk_range_q  <= 1'b0;
      step_q       <= '0;
      left_q       <= '0;
      t_q          <= '0;
      amt_q        <= '0;
      x_q          <= '0;
      word_o       <= '0;
      word_valid_o <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      word_valid_o <= 1'b0;
      done_o       <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (load_acc) begin
            st_q[load_slot_i] <= load_seed_i;
            md_q[load_slot_i] <= load_mod_i;
            chk_slot_q        <= load_slot_i;
            chk_range_q       <= (load_seed_i >= XW'(2)) && (load_mod_i >= XW'(2));
            state_q           <= S_CHK;
          end else if (start_acc) begin
            left_q  <= n_words_i;
            step_q  <= '0;
            state_q <= S_ISSUE;
          end
        end
        S_CHK: begin
          if (chk_done) begin
            bad_q[chk_slot_q] <= !(chk_cop && chk_range_q);
            state_q           <= S_IDLE;
          end
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: begin
          if (red_done) begin
            t_q   <= t_nx;
            amt_q <= amt_nx;
            if (call_end) begin
              for (int i = 0; i < NGEN; i++) st_q[i] <= st_rot[i];
            end else begin
              st_q[gen_sel] <= red_r;
            end
            if (word_end) begin
              x_q          <= x_q ^ t_nx;
              word_o       <= x_q ^ t_nx;
              word_valid_o <= 1'b1;
              step_q       <= '0;
              left_q       <= left_q - 1'b1;
              if (call_end) begin
                done_o  <= 1'b1;
                state_q <= S_IDLE;
              end else begin
                state_q <= S_ISSUE;
              end
            end else begin
              step_q  <= step_q + 1'b1;
              state_q <= S_ISSUE;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bbs_word_gen_chk.sv
module bbs_word_gen_chk #(
  parameter int unsigned XW = 16,
  parameter int unsigned WW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          load_i,
  input logic          start_i,
  input logic          busy_o,
  input logic          load_err_o,
  input logic [WW-1:0] word_o,
  input logic          word_valid_o,
  input logic          done_o,
  input logic          run_phase,
  input logic          red_done,
  input logic [XW-1:0] red_r,
  input logic [XW-1:0] cur_mod
);
  p_rem_below_mod_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    red_done |-> (red_r < cur_mod));

  p_valid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);

  p_word_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_o) |-> word_valid_o);

  p_err_blocks_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && load_err_o && start_i && !load_i) |=> !busy_o);

  p_load_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_phase && load_i) |=> $stable(load_err_o));

  p_done_last_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (word_valid_o && !busy_o));
endmodule

bind bbs_word_gen bbs_word_gen_chk #(.XW(XW), .WW(WW)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .start_i(start_i),
  .busy_o(busy_o), .load_err_o(load_err_o), .word_o(word_o),
  .word_valid_o(word_valid_o), .done_o(done_o), .run_phase(run_phase),
  .red_done(red_done), .red_r(red_r), .cur_mod(cur_mod)
);

// File: tb/bbs_word_gen_tb_top.sv
module bbs_word_gen_tb_top;
  localparam int STEP_CYC = 34;
  localparam int WORD_CYC = 12 * STEP_CYC;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [2:0]  load_slot_i = '0;
  logic [15:0] load_seed_i = '0;
  logic [15:0] load_mod_i = '0;
  logic        start_i = 1'b0;
  logic [7:0]  n_words_i = '0;
  logic        busy_o, load_err_o, word_valid_o, done_o;
  logic [31:0] word_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  longint mst [8];
  longint mmd [8];
  bit     mbad [8];
  logic [31:0] mx = '0;

  int mods [8] = '{59989, 50621, 41989, 56977, 53297, 45173, 52961, 44377};

  bbs_word_gen dut_i (.*);

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  initial begin
    wait (cyc > 150000);
    n_bad++;
    $display("FAIL watchdog: run hung, act cycles=%0d exp below 150000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic longint gcd(input longint a, input longint b);
    while (b != 0) begin
      longint t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  function automatic bit any_bad();
    for (int i = 0; i < 8; i++) if (mbad[i]) return 1'b1;
    return 1'b0;
  endfunction

  // model of R1/R3/R4/R5: one word, updates model state
  task automatic model_word(output logic [31:0] w);
    int sched [12] = '{0, 1, 2, 3, 4, 5, 6, 7, 2, 0, 6, 1};
    logic [31:0] t = '0;
    int a = 0;
    for (int k = 0; k < 12; k++) begin
      int s = sched[k];
      longint r;
      int msk;
      mst[s] = (mst[s] * mst[s]) % mmd[s];
      r = mst[s];
      msk = (a == 0) ? 0 : (a == 1) ? 1 : (a == 2) ? 3 : 7;
      if (k < 8) t = {t[27:0], 4'(r)};
      else if (k == 8 || k == 10) a = int'(r & 3);
      else t = (t << a) | 32'(r & msk);
    end
    mx = mx ^ t;
    w = mx;
  endtask

  task automatic do_load(input int slot, input int seed, input int md);
    @(negedge clk_i);
    load_i = 1'b1; load_slot_i = 3'(slot); load_seed_i = 16'(seed); load_mod_i = 16'(md);
    @(negedge clk_i);
    load_i = 1'b0;
    while (busy_o) @(negedge clk_i);
    mst[slot] = seed;
    mmd[slot] = md;
    mbad[slot] = (seed < 2) || (md < 2) || (gcd(seed, md) != 1);
    check(load_err_o == any_bad(), "R7 load_err", load_err_o, any_bad());
  endtask

  function automatic int good_seed(input int md);
    int s;
    do s = int'($urandom % md); while (s < 2 || gcd(s, md) != 1);
    return s;
  endfunction

  task automatic run_call(input int n, input bit poke_load);
    logic [31:0] exp_w;
    int last_cyc = 0;
    @(negedge clk_i);
    start_i = 1'b1; n_words_i = 8'(n);
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R8 call started", busy_o, 1);
    for (int w = 0; w < n; w++) begin
      while (!word_valid_o) begin
        @(negedge clk_i);
        if (poke_load && w == 0 && busy_o && !word_valid_o) begin
          load_i = 1'b1; load_slot_i = 3'd0; load_seed_i = 16'd0; load_mod_i = 16'd4;
        end else load_i = 1'b0;
      end
      load_i = 1'b0;
      model_word(exp_w);
      check(word_o == exp_w, "R5 word value (R1 R3 R4 R6)", word_o, exp_w);
      if (w > 0) check(cyc - last_cyc == WORD_CYC, "R1 word spacing", cyc - last_cyc, WORD_CYC);
      last_cyc = cyc;
      check(done_o == (w == n - 1), "R10 done_o", done_o, (w == n - 1));
      if (w == n - 1) check(busy_o == 1'b0, "R10 busy low at end", busy_o, 0);
      @(negedge clk_i);
      check(word_valid_o == 1'b0, "R5 valid pulse", word_valid_o, 0);
    end
    // R6: rotate model states one slot up
    begin
      longint tmp = mst[7];
      for (int i = 7; i > 0; i--) mst[i] = mst[i - 1];
      mst[0] = tmp;
    end
    if (poke_load) check(load_err_o == 1'b0, "R9 load ignored mid-call", load_err_o, 0);
  endtask

  task automatic try_blocked_start(input int n, input string req);
    logic [31:0] w0;
    w0 = word_o;
    @(negedge clk_i);
    start_i = 1'b1; n_words_i = 8'(n);
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(busy_o == 1'b0, req, busy_o, 0);
    check(word_o == w0, req, word_o, w0);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    for (int i = 0; i < 8; i++) begin mst[i] = 0; mmd[i] = 0; mbad[i] = 1'b1; end
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check(busy_o == 0 && word_valid_o == 0 && done_o == 0, "R11 reset controls", busy_o, 0);
    check(word_o == 0, "R11 reset word", word_o, 0);
    check(load_err_o == 1, "R11 reset load_err", load_err_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    try_blocked_start(2, "R8 start blocked after reset");

    for (int i = 0; i < 8; i++) do_load(i, good_seed(mods[i]), mods[i]);
    check(load_err_o == 0, "R7 all slots good", load_err_o, 0);

    // R7 rejections, each blocks start (R8), then cleared
    do_load(3, 0, mods[3]);
    try_blocked_start(1, "R8 start blocked by seed 0");
    do_load(5, 1, mods[5]);
    do_load(1, 239, mods[0]);
    do_load(2, 4, 50000);
    do_load(6, 7, 1);
    try_blocked_start(1, "R8 start blocked by rejected slots");
    do_load(3, good_seed(mods[3]), mods[3]);
    do_load(5, good_seed(mods[5]), mods[5]);
    do_load(1, good_seed(mods[1]), mods[1]);
    do_load(2, good_seed(mods[2]), mods[2]);
    do_load(6, good_seed(mods[6]), mods[6]);
    check(load_err_o == 0, "R7 rejection cleared", load_err_o, 0);

    try_blocked_start(0, "R8 zero-length call ignored");

    run_call(1, 1'b0);
    run_call(3, 1'b1);
    run_call(2, 1'b0);

    for (int round = 0; round < 3; round++) begin
      for (int i = 0; i < 8; i++)
        if ($urandom % 2 == 1) do_load(i, good_seed(mods[i]), mods[i]);
      run_call(int'($urandom % 4) + 1, round == 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule